// File: doc/BRIEF.md
# Vectored interrupt controller with priority slots

The block gathers 32 level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. Each source reaches the controller on a hardware line and through a software-set bit; the two are ORed. A source counts only while it is enabled, and a per-source select bit steers it to one of the two outputs. Enable and software bits are changed only through separate write-one-to-set and write-one-to-clear registers, so a handler can change one source without a read-modify-write race.

Normal requests are ranked through sixteen programmable slots. Each slot names one source and carries its own vector address; a lower slot number wins. An enabled normal source that no enabled slot names is served through a default vector at the lowest rank. Software reads the vector address register to fetch the vector of the best eligible request, which also enters that rank into a nesting record. Until service ends, only strictly higher ranks can raise the normal line. A write of any value to the same register ends the most recently entered rank, so matched read/write pairs unwind nested service.

The register bus is a single-cycle, memory-mapped port with a 12-bit byte address. Read data is combinational from the address during a read cycle. Four byte-wide identification registers near the top of the map return a fixed part code.

Top module: `vic_ctrl`

## Requirements
- R1: A write to offset 0x010 sets every enable bit written as 1. A write to 0x014 clears every enable bit written as 1. Zero bits leave enables unchanged. A read of 0x010 returns the enable word.
- R2: A write to 0x018 sets soft bits and a write to 0x01C clears them, with the same one-bit rule as R1. A read of 0x018 returns the soft word. A soft bit asserts its source just as the hardware line does.
- R3: Select register 0x00C: bit value 1 routes an enabled active source to `irq_fast` and 0 routes it to the normal path. `irq_fast` is high exactly while at least one such fast source is active.
- R4: A read of 0x000 returns lines OR soft. A read of 0x004 returns that value ANDed with enable and with NOT select. A read of 0x008 returns it ANDed with enable and with select.
- R5: Slot i (0 to 15) has a vector word at 0x100+4i and a control word at 0x200+4i. In the control word, bit 5 enables the slot and bits 4:0 name the source. Among eligible slots the lowest number wins.
- R6: The default vector at 0x024 is returned for an enabled normal source that no enabled slot names. It ranks below every slot.
- R7: `irq_normal` is high exactly while some pending rank is strictly higher than every rank in service. A read of 0x020 returns that rank's vector and enters the rank into service.
- R8: Any write to 0x020 ends the most recently entered rank still in service. A write with nothing in service has no effect.
- R9: A read of 0x020 while no rank is eligible returns the default vector and leaves the service record unchanged.
- R10: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return ID bytes 0x90, 0x11, 0x04 and 0x00 in bits 7:0. Combined low byte first, they give 0x00041190, whose bits 19:12 hold 0x41.
- R11: After reset, the enable, soft, select, slot control, slot vector and default vector registers are zero. Nothing is in service and both outputs are low.
- R12: Sources are not latched. When a source's line and soft bit are both low, that source stops contributing to either output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive hardware interrupt lines |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| irq_normal | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The ranking logic is tested with sources at three slot ranks that are raised one by one while lower ranks are in service. This shows whether a nested request preempts only from a strictly higher rank, and whether the service record unwinds in the right order. Sources that no slot names are mixed with slotted ones, and a slot is disabled while its source is active, which separates the default path from slot matching. Soft bits and hardware lines are also used alone and together, and the select bit is flipped, which separates the OR merge from fast routing. A cycle-by-cycle model checks both request lines on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFF_RAW      = 12'h000;
    localparam logic [AW-1:0] OFF_NSTAT    = 12'h004;
    localparam logic [AW-1:0] OFF_FSTAT    = 12'h008;
    localparam logic [AW-1:0] OFF_SELECT   = 12'h00C;
    localparam logic [AW-1:0] OFF_EN_SET   = 12'h010;
    localparam logic [AW-1:0] OFF_EN_CLR   = 12'h014;
    localparam logic [AW-1:0] OFF_SOFT_SET = 12'h018;
    localparam logic [AW-1:0] OFF_SOFT_CLR = 12'h01C;
    localparam logic [AW-1:0] OFF_VADDR    = 12'h020;
    localparam logic [AW-1:0] OFF_DVEC     = 12'h024;

    localparam logic [3:0] BANK_VEC = 4'h1;
    localparam logic [3:0] BANK_CTL = 4'h2;
    localparam logic [7:0] BANK_ID  = 8'hFE;

    localparam logic [31:0] PART_ID = 32'h0004_1190;
endpackage

// File: rtl/vic_slot_arb.sv
module vic_slot_arb #(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int SW    = $clog2(NSRC),
    parameter int LW    = $clog2(NSLOT + 1)
) (
    input  logic [NSRC-1:0]          norm_pend,
    input  logic [NSLOT-1:0]         slot_on,
    input  logic [NSLOT-1:0][SW-1:0] slot_src,
    input  logic [NSLOT:0]           nest,
    output logic                     win_valid,
    output logic [LW-1:0]            win_lvl
);
    localparam int NLVL = NSLOT + 1;

    logic [NLVL-1:0] lvl_req;
    logic [NLVL-1:0] open_lvl;
    logic [NLVL-1:0] elig;
    logic [NSRC-1:0] covered;

    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_hit
            assign lvl_req[gi] = slot_on[gi] & norm_pend[slot_src[gi]];
        end
        assign open_lvl[0] = ~nest[0];
        for (gi = 1; gi < NLVL; gi++) begin : g_open
            assign open_lvl[gi] = open_lvl[gi-1] & ~nest[gi];
        end
    endgenerate

    always_comb begin
        covered = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_on[i]) covered[slot_src[i]] = 1'b1;
        end
    end

    assign lvl_req[NSLOT] = |(norm_pend & ~covered);
    assign elig           = lvl_req & open_lvl;

    always_comb begin
        win_valid = |elig;
        win_lvl   = '0;
        for (int j = NLVL - 1; j >= 0; j--) begin
            if (elig[j]) win_lvl = LW'(j);
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
    parameter int NLVL = 17,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [LW-1:0]   push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] nest
);
    // One bit per rank; the lowest set bit is the rank most recently entered,
    // because only a strictly higher rank can ever be pushed on top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nest <= '0;
        end else if (pop) begin
            nest <= nest & (nest - NLVL'(1));
        end else if (push) begin
            nest[push_lvl] <= 1'b1;
        end
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_lines,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_normal,
    output logic            irq_fast
);
    localparam int SW   = $clog2(NSRC);
    localparam int SLW  = $clog2(NSLOT);
    localparam int NLVL = NSLOT + 1;
    localparam int LW   = $clog2(NLVL + 1);

    logic [NSRC-1:0]          en_q, soft_q, sel_q;
    logic [DW-1:0]            dvec_q;
    logic [NSLOT-1:0]         slot_on;
    logic [NSLOT-1:0][SW-1:0] slot_src;
    logic [NSLOT-1:0][DW-1:0] slot_vec;
    logic [NLVL-1:0]          nest_q;

    logic [NSRC-1:0] raw, norm_pend, fast_pend;
    logic            wr_cyc, rd_cyc, vec_rd, vec_wr;
    logic            in_vec_bank, in_ctl_bank, slot_ok;
    logic [SLW-1:0]  slot_sel;
    logic            win_valid;
    logic [LW-1:0]   win_lvl;
    logic [DW-1:0]   cur_vec;

    assign raw       = irq_lines | soft_q;
    assign norm_pend = raw & en_q & ~sel_q;
    assign fast_pend = raw & en_q & sel_q;

    assign wr_cyc      = bus_sel & bus_wr;
    assign rd_cyc      = bus_sel & ~bus_wr;
    assign vec_rd      = rd_cyc & (bus_addr == OFF_VADDR);
    assign vec_wr      = wr_cyc & (bus_addr == OFF_VADDR);
    assign in_vec_bank = (bus_addr[11:8] == BANK_VEC);
    assign in_ctl_bank = (bus_addr[11:8] == BANK_CTL);
    assign slot_ok     = (32'(bus_addr[7:2]) < NSLOT);
    assign slot_sel    = bus_addr[2 +: SLW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            soft_q <= '0;
            sel_q  <= '0;
            dvec_q <= '0;
        end else if (wr_cyc) begin
            case (bus_addr)
                OFF_SELECT:   sel_q  <= bus_wdata[NSRC-1:0];
                OFF_EN_SET:   en_q   <= en_q | bus_wdata[NSRC-1:0];
                OFF_EN_CLR:   en_q   <= en_q & ~bus_wdata[NSRC-1:0];
                OFF_SOFT_SET: soft_q <= soft_q | bus_wdata[NSRC-1:0];
                OFF_SOFT_CLR: soft_q <= soft_q & ~bus_wdata[NSRC-1:0];
                OFF_DVEC:     dvec_q <= bus_wdata;
                default:      ;
            endcase
        end
    end

    genvar gs;
    generate
        for (gs = 0; gs < NSLOT; gs++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_on[gs]  <= 1'b0;
                    slot_src[gs] <= '0;
                    slot_vec[gs] <= '0;
                end else if (wr_cyc && slot_ok && slot_sel == SLW'(gs)) begin
                    if (in_ctl_bank) begin
                        slot_on[gs]  <= bus_wdata[SW];
                        slot_src[gs] <= bus_wdata[SW-1:0];
                    end
                    if (in_vec_bank) slot_vec[gs] <= bus_wdata;
                end
            end
        end
    endgenerate

    vic_slot_arb #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .LW(LW)) u_arb (
        .norm_pend (norm_pend),
        .slot_on   (slot_on),
        .slot_src  (slot_src),
        .nest      (nest_q),
        .win_valid (win_valid),
        .win_lvl   (win_lvl)
    );

    vic_nest_stack #(.NLVL(NLVL), .LW(LW)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (vec_rd & win_valid),
        .push_lvl (win_lvl),
        .pop      (vec_wr),
        .nest     (nest_q)
    );

    always_comb begin
        if (!win_valid || win_lvl == LW'(NSLOT)) cur_vec = dvec_q;
        else                                     cur_vec = slot_vec[win_lvl[SLW-1:0]];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_RAW:      bus_rdata[NSRC-1:0] = raw;
            OFF_NSTAT:    bus_rdata[NSRC-1:0] = norm_pend;
            OFF_FSTAT:    bus_rdata[NSRC-1:0] = fast_pend;
            OFF_SELECT:   bus_rdata[NSRC-1:0] = sel_q;
            OFF_EN_SET:   bus_rdata[NSRC-1:0] = en_q;
            OFF_SOFT_SET: bus_rdata[NSRC-1:0] = soft_q;
            OFF_VADDR:    bus_rdata           = cur_vec;
            OFF_DVEC:     bus_rdata           = dvec_q;
            default: begin
                if (in_ctl_bank && slot_ok)
                    bus_rdata[SW:0] = {slot_on[slot_sel], slot_src[slot_sel]};
                else if (in_vec_bank && slot_ok)
                    bus_rdata = slot_vec[slot_sel];
                else if (bus_addr[11:4] == BANK_ID)
                    bus_rdata[7:0] = PART_ID[8*bus_addr[3:2] +: 8];
            end
        endcase
    end

    assign irq_normal = win_valid;
    assign irq_fast   = |fast_pend;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NLVL = 17
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_lines,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [NSRC-1:0] soft_q,
    input logic [NSRC-1:0] en_q,
    input logic [NLVL-1:0] nest_q,
    input logic            irq_normal,
    input logic            irq_fast
);
    logic vrd, vwr, eclr;
    assign vrd  = bus_sel && !bus_wr && bus_addr == OFF_VADDR;
    assign vwr  = bus_sel && bus_wr && bus_addr == OFF_VADDR;
    assign eclr = bus_sel && bus_wr && bus_addr == OFF_EN_CLR;

    // R12
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_lines | soft_q) == '0) |-> (!irq_normal && !irq_fast));

    // R7
    enter_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd && irq_normal) |=> ($countones(nest_q) == $past($countones(nest_q)) + 1));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd && !irq_normal) |=> $stable(nest_q));

    // R8
    end_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vwr && nest_q != '0) |=> ($countones(nest_q) + 1 == $past($countones(nest_q))));

    // R1
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eclr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_q == '0 && nest_q == '0));
endmodule

bind vic_ctrl vic_ctrl_chk #(.NSRC(NSRC), .NLVL(NSLOT + 1)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .soft_q     (soft_q),
    .en_q       (en_q),
    .nest_q     (nest_q),
    .irq_normal (irq_normal),
    .irq_fast   (irq_fast)
);

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
    import vic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lines;
    logic        sel, wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irqn, irqf;

    always #5 clk = ~clk;

    vic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_normal(irqn), .irq_fast(irqf)
    );

    int checks = 0;
    int errors = 0;
    bit running = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_en, m_soft, m_sel, m_dvec;
    bit          m_on [16];
    int          m_src [16];
    logic [31:0] m_vec [16];
    int          q [$];

    function automatic int best_lvl();
        logic [31:0] pend;
        int thr;
        bit cov;
        pend = (lines | m_soft) & m_en & ~m_sel;
        thr = (q.size() > 0) ? q[0] : 17;
        for (int j = 0; j < 16; j++)
            if (j < thr && m_on[j] && pend[m_src[j]]) return j;
        if (thr > 16) begin
            for (int s = 0; s < 32; s++) begin
                if (pend[s]) begin
                    cov = 0;
                    for (int j = 0; j < 16; j++)
                        if (m_on[j] && m_src[j] == s) cov = 1;
                    if (!cov) return 16;
                end
            end
        end
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk("R7 irq_normal", {31'b0, irqn}, {31'b0, best_lvl() >= 0});
            chk("R3 irq_fast", {31'b0, irqf}, {31'b0, |((lines | m_soft) & m_en & m_sel)});
        end
    end

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        sel = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 0; wr = 0;
        case (a)
            OFF_SELECT:   m_sel  = d;
            OFF_EN_SET:   m_en   = m_en | d;
            OFF_EN_CLR:   m_en   = m_en & ~d;
            OFF_SOFT_SET: m_soft = m_soft | d;
            OFF_SOFT_CLR: m_soft = m_soft & ~d;
            OFF_DVEC:     m_dvec = d;
            OFF_VADDR:    if (q.size() > 0) void'(q.pop_front());
            default: begin
                if (a[11:8] == 4'h1) m_vec[a[7:2]] = d;
                if (a[11:8] == 4'h2) begin
                    m_on[a[7:2]]  = d[5];
                    m_src[a[7:2]] = int'(d[4:0]);
                end
            end
        endcase
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        int b;
        @(posedge clk); #1;
        sel = 1; wr = 0; addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
        b = best_lvl();
        @(posedge clk); #1;
        sel = 0;
        if (a == OFF_VADDR && b >= 0) q.push_front(b);
    endtask

    task automatic set_lines(input logic [31:0] v);
        @(posedge clk); #1;
        lines = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; lines = '0; sel = 0; wr = 0; addr = '0; wdata = '0;
        m_en = '0; m_soft = '0; m_sel = '0; m_dvec = '0;
        for (int i = 0; i < 16; i++) begin m_on[i] = 0; m_src[i] = 0; m_vec[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        running = 1;

        // R11 reset state
        rd_chk("R11 enable", OFF_EN_SET, 32'h0);
        rd_chk("R11 soft", OFF_SOFT_SET, 32'h0);
        rd_chk("R11 select", OFF_SELECT, 32'h0);
        rd_chk("R11 slot ctl", 12'h20C, 32'h0);
        rd_chk("R11 slot vec", 12'h104, 32'h0);

        // R1 set/clear enable
        wr_reg(OFF_EN_SET, 32'hF0);
        wr_reg(OFF_EN_SET, 32'h03);
        rd_chk("R1 enable after sets", OFF_EN_SET, 32'hF3);
        wr_reg(OFF_EN_CLR, 32'h21);
        rd_chk("R1 enable after clear", OFF_EN_SET, 32'hD2);

        // R2 soft set/clear
        wr_reg(OFF_SOFT_SET, 32'h4);
        wr_reg(OFF_SOFT_SET, 32'h8);
        wr_reg(OFF_SOFT_CLR, 32'h4);
        rd_chk("R2 soft word", OFF_SOFT_SET, 32'h8);

        // R4 status views
        set_lines(32'h100);
        rd_chk("R4 raw", OFF_RAW, 32'h108);
        wr_reg(OFF_EN_SET, 32'h100);
        rd_chk("R4 normal status", OFF_NSTAT, 32'h100);
        wr_reg(OFF_SELECT, 32'h100);
        rd_chk("R4 normal status routed", OFF_NSTAT, 32'h0);
        rd_chk("R3 fast status", OFF_FSTAT, 32'h100);
        // R2 soft merge on normal path
        wr_reg(OFF_SOFT_SET, 32'h2);
        rd_chk("R2 soft in normal status", OFF_NSTAT, 32'h2);
        set_lines(32'h0);
        rd_chk("R3 fast status cleared", OFF_FSTAT, 32'h0);

        // clear and program slots
        wr_reg(OFF_EN_CLR, 32'hFFFF_FFFF);
        wr_reg(OFF_SOFT_CLR, 32'hFFFF_FFFF);
        wr_reg(OFF_SELECT, 32'h0);
        wr_reg(12'h100, 32'h1000); wr_reg(12'h200, 32'h27);
        wr_reg(12'h10C, 32'h1030); wr_reg(12'h20C, 32'h24);
        wr_reg(12'h124, 32'h1090); wr_reg(12'h224, 32'h26);
        wr_reg(OFF_DVEC, 32'hDEF0);
        rd_chk("R5 slot ctl readback", 12'h20C, 32'h24);
        wr_reg(OFF_EN_SET, 32'h0010_00D0);

        // R7 nesting
        set_lines(32'h40);
        rd_chk("R7 vector slot9", OFF_VADDR, 32'h1090);
        set_lines(32'h50);
        rd_chk("R7 vector slot3 nested", OFF_VADDR, 32'h1030);
        set_lines(32'hD0);
        rd_chk("R5 vector slot0 nested", OFF_VADDR, 32'h1000);
        wr_reg(OFF_VADDR, 32'h0);
        set_lines(32'h50);
        rd_chk("R9 idle read", OFF_VADDR, 32'hDEF0);
        wr_reg(OFF_VADDR, 32'h0);
        wr_reg(OFF_VADDR, 32'h0);
        rd_chk("R8 after unwind", OFF_VADDR, 32'h1030);
        wr_reg(OFF_VADDR, 32'h0);
        wr_reg(OFF_VADDR, 32'h0);

        // R6 default vector
        set_lines(32'h0010_0040);
        rd_chk("R6 slot beats default", OFF_VADDR, 32'h1090);
        wr_reg(OFF_VADDR, 32'h0);
        set_lines(32'h0010_0000);
        rd_chk("R6 default vector", OFF_VADDR, 32'hDEF0);
        set_lines(32'h0010_0010);
        rd_chk("R6 slot preempts default", OFF_VADDR, 32'h1030);
        wr_reg(OFF_VADDR, 32'h0);
        wr_reg(OFF_VADDR, 32'h0);
        set_lines(32'h0);

        // R5 disabled slot falls to default
        wr_reg(12'h20C, 32'h04);
        set_lines(32'h10);
        rd_chk("R5 disabled slot", OFF_VADDR, 32'hDEF0);
        wr_reg(OFF_VADDR, 32'h0);
        set_lines(32'h0);

        // R12 level behaviour, R2 soft on an unread source
        set_lines(32'h40);
        set_lines(32'h0);
        wr_reg(OFF_SOFT_SET, 32'h40);
        wr_reg(OFF_SOFT_CLR, 32'h40);
        rd_chk("R12 quiet status", OFF_NSTAT, 32'h0);

        // R3 fast routing with soft bit
        wr_reg(OFF_SELECT, 32'h80);
        wr_reg(OFF_SOFT_SET, 32'h80);
        rd_chk("R3 fast routed", OFF_FSTAT, 32'h80);
        wr_reg(OFF_SOFT_CLR, 32'h80);

        // R10 identification
        rd_chk("R10 id0", 12'hFE0, 32'h90);
        rd_chk("R10 id1", 12'hFE4, 32'h11);
        rd_chk("R10 id2", 12'hFE8, 32'h04);
        rd_chk("R10 id3", 12'hFEC, 32'h00);

        repeat (2) @(posedge clk);
        running = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule